// File: doc/BRIEF.md
# Instruction Prefix Register Remapper

This block sits in the decode path of an 8-bit accumulator processor whose visible registers are A, X, Y, S and P. It watches the opcode stream for one of four prefix bytes. When one arrives it records which register substitution was asked for. It then rewrites the register-select fields of the single instruction that follows, so an unchanged legacy opcode runs with a different register in place of the accumulator or the index. A prefix brings no new operation. It only changes which registers the next instruction names.

The decoder feeds in the register selects of the base instruction: a source operand, a destination operand and an index register. It also gives a valid strobe with each fetched opcode and a strobe at the end of each instruction. The block returns the rewritten selects one cycle later, along with the high address byte used for zero-page accesses. It raises a one-cycle stall for the extra fetch that the prefix costs. It also holds off interrupts from the moment a prefix is taken until its instruction completes, so that a prefix and its instruction are never split.

Top module: `prefix_remap`

## Requirements
- R1: While `rst` is high at a clock edge, every select output goes to code 0 at that edge, `zp_hi_o` goes to 0x00, and `stall_o` and `irq_hold_o` go low.
- R2: With no prefix active, each select output equals its input from the previous cycle and `zp_hi_o` is 0x00. Register codes are: A=0, X=1, Y=2, S=3, P=4.
- R3: After prefix 0x03, the instruction that follows sees code 1 (X) in place of code 0 (A) in its source and destination selects. The index select is unchanged.
- R4: After prefix 0x13, the instruction that follows sees code 2 (Y) in place of code 0 (A) in its source and destination selects. The index select is unchanged.
- R5: After prefix 0x23, the instruction that follows sees code 3 (S) in place of code 1 (X) in its index select, and `zp_hi_o` is 0x01 (the stack page) in place of 0x00. The source and destination selects are unchanged.
- R6: After prefix 0x33, the instruction that follows sees codes 1 and 2 exchanged in all three selects.
- R7: `stall_o` is high in exactly the cycle after each prefix fetch (`op_valid` high with a prefix opcode), and low otherwise.
- R8: An `insn_done` strobe with no prefix fetch in the same cycle clears the active substitution. From the next cycle on, selects pass through unchanged.
- R9: A prefix fetched while another prefix is active replaces it. Only the later substitution applies to the next instruction.
- R10: `irq_hold_o` is high from the cycle after a prefix fetch until the cycle after the `insn_done` that ends the prefixed instruction.
- R11: When a prefix fetch and `insn_done` fall in the same cycle, the new prefix is taken and stays active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | `opcode` holds a freshly fetched opcode byte |
| opcode | input | 8 | Fetched opcode byte |
| insn_done | input | 1 | Current instruction completes this cycle |
| src_sel_i | input | 3 | Source operand register select of the base instruction |
| dst_sel_i | input | 3 | Destination register select of the base instruction |
| idx_sel_i | input | 3 | Index register select of the base instruction |
| src_sel_o | output | 3 | Remapped source select (registered) |
| dst_sel_o | output | 3 | Remapped destination select (registered) |
| idx_sel_o | output | 3 | Remapped index select (registered) |
| zp_hi_o | output | 8 | High address byte for zero-page accesses |
| stall_o | output | 1 | Extra cycle for the prefix fetch |
| irq_hold_o | output | 1 | Interrupt acceptance must wait |

## Verification
The prefix load and the end-of-instruction clear can fall in the same cycle. That happens when a prefix is fetched in the cycle that the previous instruction finishes. The bench drives `insn_done` together with a prefix fetch, both from an idle state and with another prefix already active. It then judges the outcome by the selects of the next instruction and by `irq_hold_o`, both of which must reflect the new prefix. A back-to-back pair of prefixes probes how a replacement interacts with the stall, which must then cover both fetch cycles.

// File: rtl/prefix_remap_pkg.sv
package prefix_remap_pkg;
  localparam int REG_W = 3;

  localparam logic [REG_W-1:0] RSEL_A = 3'd0;
  localparam logic [REG_W-1:0] RSEL_X = 3'd1;
  localparam logic [REG_W-1:0] RSEL_Y = 3'd2;
  localparam logic [REG_W-1:0] RSEL_S = 3'd3;

  typedef enum logic [2:0] {
    MODE_NONE    = 3'd0,
    MODE_X_ACC   = 3'd1,
    MODE_Y_ACC   = 3'd2,
    MODE_S_IDX   = 3'd3,
    MODE_XY_SWAP = 3'd4
  } pfx_mode_e;

  // Select field roles: operand fields follow accumulator substitution,
  // the index field follows index substitution.
  typedef enum logic {
    ROLE_OPERAND = 1'b0,
    ROLE_INDEX   = 1'b1
  } sel_role_e;
endpackage

// File: rtl/prefix_decode.sv
module prefix_decode
  import prefix_remap_pkg::*;
#(
  parameter logic [7:0] P_XA = 8'h03,
  parameter logic [7:0] P_YA = 8'h13,
  parameter logic [7:0] P_SX = 8'h23,
  parameter logic [7:0] P_XY = 8'h33
) (
  input  logic       op_valid,
  input  logic [7:0] opcode,
  output logic       pfx_hit,
  output pfx_mode_e  pfx_mode
);
  always_comb begin
    pfx_mode = MODE_NONE;
    unique case (opcode)
      P_XA:    pfx_mode = MODE_X_ACC;
      P_YA:    pfx_mode = MODE_Y_ACC;
      P_SX:    pfx_mode = MODE_S_IDX;
      P_XY:    pfx_mode = MODE_XY_SWAP;
      default: pfx_mode = MODE_NONE;
    endcase
    pfx_hit = op_valid && (pfx_mode != MODE_NONE);
  end
endmodule

// File: rtl/prefix_latch.sv
module prefix_latch
  import prefix_remap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pfx_hit,
  input  pfx_mode_e pfx_mode,
  input  logic      insn_done,
  output pfx_mode_e mode_q,
  output logic      stall_q
);
  // A new prefix outranks the end-of-instruction clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_NONE;
      stall_q <= 1'b0;
    end else begin
      stall_q <= pfx_hit;
      if (pfx_hit)
        mode_q <= pfx_mode;
      else if (insn_done)
        mode_q <= MODE_NONE;
    end
  end
endmodule

// File: rtl/sel_remap.sv
module sel_remap
  import prefix_remap_pkg::*;
#(
  parameter sel_role_e ROLE = ROLE_OPERAND
) (
  input  logic             clk,
  input  logic             rst,
  input  pfx_mode_e        mode,
  input  logic [REG_W-1:0] sel_in,
  output logic [REG_W-1:0] sel_out
);
  logic [REG_W-1:0] mapped;

  always_comb begin
    mapped = sel_in;
    unique case (mode)
      MODE_X_ACC:
        if (ROLE == ROLE_OPERAND && sel_in == RSEL_A) mapped = RSEL_X;
      MODE_Y_ACC:
        if (ROLE == ROLE_OPERAND && sel_in == RSEL_A) mapped = RSEL_Y;
      MODE_S_IDX:
        if (ROLE == ROLE_INDEX && sel_in == RSEL_X) mapped = RSEL_S;
      MODE_XY_SWAP:
        if (sel_in == RSEL_X)      mapped = RSEL_Y;
        else if (sel_in == RSEL_Y) mapped = RSEL_X;
      default: mapped = sel_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sel_out <= '0;
    else     sel_out <= mapped;
  end
endmodule

// File: rtl/prefix_remap.sv
module prefix_remap
  import prefix_remap_pkg::*;
#(
  parameter logic [7:0] P_XA       = 8'h03,
  parameter logic [7:0] P_YA       = 8'h13,
  parameter logic [7:0] P_SX       = 8'h23,
  parameter logic [7:0] P_XY       = 8'h33,
  parameter int         AHI_W      = 8,
  parameter logic [AHI_W-1:0] ZP_PAGE    = 8'h00,
  parameter logic [AHI_W-1:0] STACK_PAGE = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [7:0]       opcode,
  input  logic             insn_done,
  input  logic [REG_W-1:0] src_sel_i,
  input  logic [REG_W-1:0] dst_sel_i,
  input  logic [REG_W-1:0] idx_sel_i,
  output logic [REG_W-1:0] src_sel_o,
  output logic [REG_W-1:0] dst_sel_o,
  output logic [REG_W-1:0] idx_sel_o,
  output logic [AHI_W-1:0] zp_hi_o,
  output logic             stall_o,
  output logic             irq_hold_o
);
  localparam int NSEL = 3;
  localparam int IDX_SLOT = NSEL - 1;

  logic      pfx_hit;
  pfx_mode_e pfx_mode;
  pfx_mode_e mode_q;
  logic [REG_W-1:0] sel_in  [NSEL];
  logic [REG_W-1:0] sel_out [NSEL];
  logic [AHI_W-1:0] zp_hi_q;

  prefix_decode #(
    .P_XA(P_XA), .P_YA(P_YA), .P_SX(P_SX), .P_XY(P_XY)
  ) u_decode (
    .op_valid (op_valid),
    .opcode   (opcode),
    .pfx_hit  (pfx_hit),
    .pfx_mode (pfx_mode)
  );

  prefix_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .pfx_hit   (pfx_hit),
    .pfx_mode  (pfx_mode),
    .insn_done (insn_done),
    .mode_q    (mode_q),
    .stall_q   (stall_o)
  );

  assign sel_in[0] = src_sel_i;
  assign sel_in[1] = dst_sel_i;
  assign sel_in[2] = idx_sel_i;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    sel_remap #(
      .ROLE((g == IDX_SLOT) ? ROLE_INDEX : ROLE_OPERAND)
    ) u_remap (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_q),
      .sel_in  (sel_in[g]),
      .sel_out (sel_out[g])
    );
  end

  assign src_sel_o = sel_out[0];
  assign dst_sel_o = sel_out[1];
  assign idx_sel_o = sel_out[2];

  always_ff @(posedge clk) begin
    if (rst) zp_hi_q <= ZP_PAGE;
    else     zp_hi_q <= (mode_q == MODE_S_IDX) ? STACK_PAGE : ZP_PAGE;
  end
  assign zp_hi_o = zp_hi_q;

  assign irq_hold_o = (mode_q != MODE_NONE);
endmodule

// File: rtl/prefix_remap_chk.sv
module prefix_remap_chk #(
  parameter logic [7:0] P_XA       = 8'h03,
  parameter logic [7:0] P_YA       = 8'h13,
  parameter logic [7:0] P_SX       = 8'h23,
  parameter logic [7:0] P_XY       = 8'h33,
  parameter int         AHI_W      = 8,
  parameter logic [AHI_W-1:0] ZP_PAGE    = 8'h00,
  parameter logic [AHI_W-1:0] STACK_PAGE = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [7:0]       opcode,
  input logic             insn_done,
  input logic [2:0]       src_sel_i,
  input logic [2:0]       dst_sel_i,
  input logic [2:0]       idx_sel_i,
  input logic [2:0]       src_sel_o,
  input logic [2:0]       dst_sel_o,
  input logic [2:0]       idx_sel_o,
  input logic [AHI_W-1:0] zp_hi_o,
  input logic             stall_o,
  input logic             irq_hold_o
);
  logic is_pfx;
  assign is_pfx = op_valid &&
    (opcode == P_XA || opcode == P_YA || opcode == P_SX || opcode == P_XY);

  AST_STALL_AFTER_PFX: assert property (@(posedge clk) disable iff (rst)
    is_pfx |=> stall_o); // R7

  AST_STALL_NEEDS_PFX: assert property (@(posedge clk) disable iff (rst)
    !is_pfx |=> !stall_o); // R7

  AST_HOLD_WITH_STALL: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> irq_hold_o); // R10

  AST_CLEAR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (insn_done && !is_pfx) |=> !irq_hold_o); // R8

  AST_PFX_OVER_DONE: assert property (@(posedge clk) disable iff (rst)
    (insn_done && is_pfx) |=> irq_hold_o); // R11

  AST_PASS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !irq_hold_o |=> (src_sel_o == $past(src_sel_i) && dst_sel_o == $past(dst_sel_i)
                     && idx_sel_o == $past(idx_sel_i) && zp_hi_o == ZP_PAGE)); // R2

  AST_STACK_PAGE_SRC: assert property (@(posedge clk) disable iff (rst)
    (zp_hi_o == STACK_PAGE) |-> $past(irq_hold_o)); // R5
endmodule

bind prefix_remap prefix_remap_chk #(
  .P_XA(P_XA), .P_YA(P_YA), .P_SX(P_SX), .P_XY(P_XY),
  .AHI_W(AHI_W), .ZP_PAGE(ZP_PAGE), .STACK_PAGE(STACK_PAGE)
) i_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode), .insn_done(insn_done),
  .src_sel_i(src_sel_i), .dst_sel_i(dst_sel_i), .idx_sel_i(idx_sel_i),
  .src_sel_o(src_sel_o), .dst_sel_o(dst_sel_o), .idx_sel_o(idx_sel_o),
  .zp_hi_o(zp_hi_o), .stall_o(stall_o), .irq_hold_o(irq_hold_o)
);

// File: tb/test_prefix_remap.sv
`timescale 1ns/1ps
module test_prefix_remap;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [7:0] opcode;
  logic       insn_done;
  logic [2:0] src_i, dst_i, idx_i;
  logic [2:0] src_o, dst_o, idx_o;
  logic [7:0] zp_hi;
  logic       stall, hold;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  prefix_remap i_prefix_remap (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode), .insn_done(insn_done),
    .src_sel_i(src_i), .dst_sel_i(dst_i), .idx_sel_i(idx_i),
    .src_sel_o(src_o), .dst_sel_o(dst_o), .idx_sel_o(idx_o),
    .zp_hi_o(zp_hi), .stall_o(stall), .irq_hold_o(hold)
  );

  // Prefix opcodes indexed by bench mode 1..4: X-for-A, Y-for-A, S-for-X, X/Y swap
  function automatic logic [7:0] pfx_code(int m);
    case (m)
      1: return 8'h03;
      2: return 8'h13;
      3: return 8'h23;
      default: return 8'h33;
    endcase
  endfunction

  // Expected select for mode m; is_idx selects the index-field rules
  function automatic logic [2:0] expect_sel(int m, bit is_idx, int c);
    case (m)
      1: return (!is_idx && c == 0) ? 3'd1 : 3'(c);
      2: return (!is_idx && c == 0) ? 3'd2 : 3'(c);
      3: return (is_idx && c == 1) ? 3'd3 : 3'(c);
      4: return (c == 1) ? 3'd2 : (c == 2) ? 3'd1 : 3'(c);
      default: return 3'(c);
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(bit v, logic [7:0] op, bit dn, int s, int d, int x);
    op_valid = v; opcode = op; insn_done = dn;
    src_i = 3'(s); dst_i = 3'(d); idx_i = 3'(x);
  endtask

  task automatic check_sels(string req, int m, int s, int d, int x);
    check(req, "src", int'(src_o), int'(expect_sel(m, 0, s)));
    check(req, "dst", int'(dst_o), int'(expect_sel(m, 0, d)));
    check(req, "idx", int'(idx_o), int'(expect_sel(m, 1, x)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(0, 8'hEA, 0, 2, 4, 1);
    @(negedge clk);
    cyc(); cyc();
    // R1: reset state
    check("R1", "src", int'(src_o), 0);
    check("R1", "idx", int'(idx_o), 0);
    check("R1", "zp_hi", int'(zp_hi), 0);
    check("R1", "stall", int'(stall), 0);
    check("R1", "hold", int'(hold), 0);
    rst = 1'b0;

    // R2: pass-through sweep with no prefix
    for (int c = 0; c < 5; c++) begin
      drive(1, 8'hEA, 1, c, 4 - c, (c + 2) % 5);
      cyc();
      check_sels("R2", 0, c, 4 - c, (c + 2) % 5);
      check("R2", "zp_hi", int'(zp_hi), 0);
      check("R7", "stall idle", int'(stall), 0);
    end

    // R3..R6, R7, R8, R10: every prefix against every select combination
    for (int m = 1; m <= 4; m++) begin
      for (int s = 0; s < 5; s++) begin
        for (int d = 0; d < 5; d++) begin
          for (int x = 0; x < 5; x++) begin
            string rq;
            rq = (m == 1) ? "R3" : (m == 2) ? "R4" : (m == 3) ? "R5" : "R6";
            drive(1, pfx_code(m), 0, 0, 0, 0);
            cyc();
            check("R7", "stall after prefix", int'(stall), 1);
            check("R10", "hold after prefix", int'(hold), 1);
            drive(1, 8'hEA, 0, s, d, x);
            cyc();
            check_sels(rq, m, s, d, x);
            check(rq, "zp_hi", int'(zp_hi), (m == 3) ? 1 : 0);
            check("R7", "stall one cycle", int'(stall), 0);
            check("R10", "hold in instruction", int'(hold), 1);
            drive(0, 8'hEA, 1, s, d, x);
            cyc();
            check("R10", "hold released", int'(hold), 0);
            drive(0, 8'hEA, 0, s, d, x);
            cyc();
            check_sels("R8", 0, s, d, x);
            check("R8", "zp_hi", int'(zp_hi), 0);
          end
        end
      end
    end

    // R9: later prefix replaces the earlier one
    drive(1, 8'h03, 0, 0, 0, 1);
    cyc();
    drive(1, 8'h23, 0, 0, 0, 1);
    cyc();
    check("R9", "stall second prefix", int'(stall), 1);
    drive(1, 8'hEA, 0, 0, 0, 1);
    cyc();
    check("R9", "src kept A", int'(src_o), 0);
    check("R9", "idx to S", int'(idx_o), 3);
    check("R9", "zp_hi", int'(zp_hi), 1);
    drive(0, 8'hEA, 1, 0, 0, 1);
    cyc();

    // R11: prefix fetch together with insn_done, from idle
    drive(1, 8'h13, 1, 0, 0, 0);
    cyc();
    check("R11", "hold idle case", int'(hold), 1);
    drive(1, 8'hEA, 0, 0, 2, 1);
    cyc();
    check("R11", "src to Y", int'(src_o), 2);
    check("R11", "dst kept", int'(dst_o), 2);
    // R11: prefix with insn_done while another prefix is active
    drive(1, 8'h33, 1, 0, 0, 0);
    cyc();
    check("R11", "hold replace case", int'(hold), 1);
    drive(1, 8'hEA, 0, 0, 1, 2);
    cyc();
    check("R11", "swap src A", int'(src_o), 0);
    check("R11", "swap dst", int'(dst_o), 2);
    check("R11", "swap idx", int'(idx_o), 1);
    drive(0, 8'hEA, 1, 0, 0, 0);
    cyc();
    check("R8", "hold final", int'(hold), 0);

    // R1: reset while a prefix is active
    drive(1, 8'h23, 0, 0, 0, 1);
    cyc();
    rst = 1'b1;
    drive(0, 8'hEA, 0, 3, 3, 1);
    cyc();
    check("R1", "hold in reset", int'(hold), 0);
    check("R1", "zp_hi in reset", int'(zp_hi), 0);
    check("R1", "dst in reset", int'(dst_o), 0);
    rst = 1'b0;

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule